// File: doc/BRIEF.md
# Chained Up/Down Counter Pair with Routable Capture

The block joins two 16-bit counters into one 32-bit position count. The low counter is stepped by a quadrature pair of phase inputs. Every valid edge on either phase moves it by one, and the phase order sets the direction. The high counter follows the low counter's wrap. It steps up when the low half rolls over upward and down when the low half rolls under downward. A bidirectional encoder count therefore stays correct across both directions.

Each half has a capture register and a capture pin. Each pin has its own edge select. A capture on the low channel stores the low count, and a capture on the high channel stores the high count. Two routing bits let a qualifying edge on one channel's pin also load the other channel's register. With that routing, one pin edge can freeze a coherent 32-bit snapshot. All pins are asynchronous and are synchronized inside the block. Configuration is one write-only word, and counts and captures are read back on plain status outputs.

Top module: `cascade_capture_top`

## Requirements
- R1: After reset, both counts and both capture registers read 0x0000, both edge selects mean rising edge, and both routing bits are clear.
- R2: With the phase state written {phase_a, phase_b}, the sequence 00, 10, 11, 01, 00 steps the low count up by one per transition, and the reverse sequence steps it down by one per transition.
- R3: A transition in which both phases change in the same sampled step leaves both counts unchanged.
- R4: When the low count goes from 0xFFFF to 0x0000 while counting up, the high count increases by one.
- R5: When the low count goes from 0x0000 to 0xFFFF while counting down, the high count decreases by one. The high count changes at no other time.
- R6: A write with cfg_we high stores cfg_wdata, laid out as bits [1:0] low-channel edge select, [3:2] high-channel edge select, bit 4 routing into the low register, and bit 5 routing into the high register. An edge select of 00 means rising, 01 falling, and 1x both edges. A pin edge that does not match its select causes no capture.
- R7: A qualifying edge on cap_pin_lo loads cap_lo with the low count, and a qualifying edge on cap_pin_hi loads cap_hi with the high count.
- R8: With bit 5 set, a qualifying edge on cap_pin_lo (judged by the low channel's select) also loads cap_hi with the high count in the same cycle as cap_lo. With bit 5 clear, cap_hi ignores cap_pin_lo.
- R9: With bit 4 clear, edges on cap_pin_hi never change cap_lo. With bit 4 set, a qualifying edge on cap_pin_hi (judged by the high channel's select) loads cap_lo with the low count.
- R10: A capture that takes effect in the same cycle as a count step records the count from before the step.
- R11: A pin or phase change takes effect on the third rising clock edge after it. The first two edges are synchronizer stages, and the new values are visible after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration word (edge selects, routing bits) |
| phase_a | input | 1 | Quadrature phase A, asynchronous |
| phase_b | input | 1 | Quadrature phase B, asynchronous |
| cap_pin_lo | input | 1 | Low-channel capture pin, asynchronous |
| cap_pin_hi | input | 1 | High-channel capture pin, asynchronous |
| cnt_lo | output | 16 | Low half of the chained count |
| cnt_hi | output | 16 | High half of the chained count |
| cap_lo | output | 16 | Low-channel capture register |
| cap_hi | output | 16 | High-channel capture register |

## Verification
Each pin or phase change is due after three rising edges: two synchronizer flops, then the edge detector feeding the counter or capture register. A configuration write is due one edge after the strobe. The bench drives inputs on falling edges and samples on falling edges. It waits four falling edges after any stimulus before it compares. One capture is checked at exactly the second and third falling edge after its pin change, which pins the latency of R11. The coincident step-and-capture case drives a phase edge and a pin edge on the same falling edge, so both arrive in the same cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CNT_W  = 16;
  localparam int SYNC_N = 2;

  localparam logic [1:0] SEL_RISE = 2'b00;
  localparam logic [1:0] SEL_FALL = 2'b01;

  typedef struct packed {
    logic       xen_hi;   // low pin also loads high register
    logic       xen_lo;   // high pin also loads low register
    logic [1:0] sel_hi;
    logic [1:0] sel_lo;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/cc_quad_dec.sv
module cc_quad_dec (
  input  logic a,
  input  logic b,
  input  logic pa,
  input  logic pb,
  output logic step,
  output logic up
);
  logic da, db;
  always_comb begin
    da   = a ^ pa;
    db   = b ^ pb;
    // exactly one phase moved; both moving is discarded
    step = da ^ db;
    up   = da ? (a ^ b) : ~(a ^ b);
  end
endmodule

// File: rtl/cc_cascade_cnt.sv
module cc_cascade_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi
);
  localparam logic [W-1:0] LO_MAX = '1;
  localparam logic [W-1:0] LO_MIN = '0;
  localparam logic [W-1:0] ONE    = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (step) begin
      if (up) begin
        cnt_lo <= cnt_lo + ONE;
        if (cnt_lo == LO_MAX) cnt_hi <= cnt_hi + ONE;
      end else begin
        cnt_lo <= cnt_lo - ONE;
        if (cnt_lo == LO_MIN) cnt_hi <= cnt_hi - ONE;
      end
    end
  end
endmodule

// File: rtl/cc_capture_ch.sv
module cc_capture_ch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sel,
  input  logic         pin_lvl,
  input  logic         pin_prev,
  input  logic         cross_ev,
  input  logic         xen,
  input  logic [W-1:0] value,
  output logic         ev,
  output logic [W-1:0] cap
);
  logic rise, fall, trig;

  always_comb begin
    rise = pin_lvl & ~pin_prev;
    fall = ~pin_lvl & pin_prev;
    if (sel[1])                    ev = rise | fall;
    else if (sel == cc_pkg::SEL_FALL) ev = fall;
    else                           ev = rise;
    trig = ev | (xen & cross_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap <= '0;
    else if (trig) cap <= value;
  end
endmodule

// File: rtl/cascade_capture_top.sv
module cascade_capture_top
  import cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             cap_pin_lo,
  input  logic             cap_pin_hi,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic [CNT_W-1:0] cap_lo,
  output logic [CNT_W-1:0] cap_hi
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  // bit order: 0 phase_a, 1 phase_b, 2 low pin, 3 high pin
  logic [3:0] s_lvl, s_prev;

  cc_sync_edge #(.W(4), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cap_pin_hi, cap_pin_lo, phase_b, phase_a}),
    .lvl  (s_lvl),
    .prev (s_prev)
  );

  logic q_step, q_up;

  cc_quad_dec u_quad (
    .a   (s_lvl[0]),
    .b   (s_lvl[1]),
    .pa  (s_prev[0]),
    .pb  (s_prev[1]),
    .step(q_step),
    .up  (q_up)
  );

  cc_cascade_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (q_step),
    .up    (q_up),
    .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi)
  );

  // channel 0 = low half, channel 1 = high half
  logic [1:0]       ch_sel  [2];
  logic             ch_xen  [2];
  logic [CNT_W-1:0] ch_val  [2];
  logic [CNT_W-1:0] ch_cap  [2];
  logic [1:0]       ch_ev;

  assign ch_sel[0] = cfg_q.sel_lo;
  assign ch_sel[1] = cfg_q.sel_hi;
  assign ch_xen[0] = cfg_q.xen_lo;
  assign ch_xen[1] = cfg_q.xen_hi;
  assign ch_val[0] = cnt_lo;
  assign ch_val[1] = cnt_hi;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    cc_capture_ch #(.W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (ch_sel[g]),
      .pin_lvl (s_lvl[2+g]),
      .pin_prev(s_prev[2+g]),
      .cross_ev(ch_ev[1-g]),
      .xen     (ch_xen[g]),
      .value   (ch_val[g]),
      .ev      (ch_ev[g]),
      .cap     (ch_cap[g])
    );
  end

  assign cap_lo = ch_cap[0];
  assign cap_hi = ch_cap[1];

  logic ev_lo, ev_hi, xen_lo, xen_hi;
  assign ev_lo  = ch_ev[0];
  assign ev_hi  = ch_ev[1];
  assign xen_lo = cfg_q.xen_lo;
  assign xen_hi = cfg_q.xen_hi;
endmodule

// File: rtl/cascade_capture_chk.sv
module cascade_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_lo,
  input logic        ev_hi,
  input logic        xen_lo,
  input logic        xen_hi,
  input logic [15:0] cnt_lo,
  input logic [15:0] cnt_hi,
  input logic [15:0] cap_lo,
  input logic [15:0] cap_hi
);
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + 16'd1) || (cnt_lo == $past(cnt_lo) - 16'd1)); // R2
  AST_UP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_lo) == 16'hFFFF && cnt_lo == 16'h0000) |-> (cnt_hi == $past(cnt_hi) + 16'd1)); // R4
  AST_DOWN_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_lo) == 16'h0000 && cnt_lo == 16'hFFFF) |-> (cnt_hi == $past(cnt_hi) - 16'd1)); // R5
  AST_HI_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hi != $past(cnt_hi)) |-> ((cnt_lo == 16'h0000 && $past(cnt_lo) == 16'hFFFF) ||
                                    (cnt_lo == 16'hFFFF && $past(cnt_lo) == 16'h0000))); // R5
  AST_LO_OWN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lo |=> (cap_lo == $past(cnt_lo))); // R7
  AST_CROSS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lo && xen_hi) |=> (cap_lo == $past(cnt_lo) && cap_hi == $past(cnt_hi))); // R8
  AST_NO_CROSS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!xen_lo && ev_hi && !ev_lo) |=> $stable(cap_lo)); // R9
endmodule

bind cascade_capture_top cascade_capture_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ev_lo (ev_lo),
  .ev_hi (ev_hi),
  .xen_lo(xen_lo),
  .xen_hi(xen_hi),
  .cnt_lo(cnt_lo),
  .cnt_hi(cnt_hi),
  .cap_lo(cap_lo),
  .cap_hi(cap_hi)
);

// File: tb/cascade_capture_top_tb.sv
module cascade_capture_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic        phase_a = 1'b0, phase_b = 1'b0;
  logic        cap_pin_lo = 1'b0, cap_pin_hi = 1'b0;
  logic [15:0] cnt_lo, cnt_hi, cap_lo, cap_hi;

  int checks = 0;
  int failures = 0;
  int qidx = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_capture_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .phase_a(phase_a), .phase_b(phase_b),
    .cap_pin_lo(cap_pin_lo), .cap_pin_hi(cap_pin_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi)
  );

  // rows: {up, steps[7:0], expected lo, expected hi}
  localparam int NVEC = 6;
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 8'd1, 16'hFFFF, 16'hFFFF},   // R5 borrow from reset
    {1'b1, 8'd1, 16'h0000, 16'h0000},   // R4 carry back
    {1'b1, 8'd3, 16'h0003, 16'h0000},   // R2 plain up
    {1'b0, 8'd5, 16'hFFFE, 16'hFFFF},   // R2 R5 down through zero
    {1'b1, 8'd2, 16'h0000, 16'h0000},   // R4
    {1'b0, 8'd1, 16'hFFFF, 16'hFFFF}    // R5
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_phase(input int idx);
    case (idx)
      0: {phase_a, phase_b} = 2'b00;
      1: {phase_a, phase_b} = 2'b10;
      2: {phase_a, phase_b} = 2'b11;
      default: {phase_a, phase_b} = 2'b01;
    endcase
  endtask

  task automatic qstep(input bit up);
    qidx = up ? (qidx + 1) % 4 : (qidx + 3) % 4;
    drive_phase(qidx);
    waitn(4);
  endtask

  task automatic cfg_write(input logic [5:0] d);
    cfg_wdata = d;
    cfg_we = 1'b1;
    waitn(1);
    cfg_we = 1'b0;
    waitn(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitn(3);
    chk("R1 cnt_lo", cnt_lo, 16'h0000);
    chk("R1 cnt_hi", cnt_hi, 16'h0000);
    chk("R1 cap_lo", cap_lo, 16'h0000);
    chk("R1 cap_hi", cap_hi, 16'h0000);
    rst_n = 1'b1;
    waitn(2);

    // R1: default config is rising edge, no routing
    cap_pin_hi = 1'b1; waitn(4);
    chk("R1 R7 default rising hi", cap_hi, 16'h0000);
    chk("R1 R9 no routing default", cap_lo, 16'h0000);
    cap_pin_hi = 1'b0; waitn(4);

    for (int v = 0; v < NVEC; v++) begin
      for (int s = 0; s < int'(VEC[v][39:32]); s++) qstep(VEC[v][40]);
      chk("R2 R4 R5 table lo", cnt_lo, VEC[v][31:16]);
      chk("R2 R4 R5 table hi", cnt_hi, VEC[v][15:0]);
    end

    // R3: both phases flip together
    qidx = (qidx + 2) % 4;
    drive_phase(qidx);
    waitn(4);
    chk("R3 invalid lo", cnt_lo, 16'hFFFF);
    chk("R3 invalid hi", cnt_hi, 16'hFFFF);
    qstep(1'b1);
    chk("R3 R4 resume up", cnt_lo, 16'h0000);
    qstep(1'b0);
    chk("R3 R5 resume down", cnt_hi, 16'hFFFF);

    // R7 R11: low capture, exact latency
    cfg_write(6'b000000);
    cap_pin_lo = 1'b1;
    waitn(2);
    chk("R11 not yet", cap_lo, 16'h0000);
    waitn(1);
    chk("R11 R7 cap_lo due", cap_lo, 16'hFFFF);
    waitn(1);
    chk("R8 no routing to hi", cap_hi, 16'h0000);
    cap_pin_lo = 1'b0; waitn(4);
    chk("R6 falling ignored on rise select", cap_lo, 16'hFFFF);

    // R9: routing off, high pin leaves cap_lo
    qstep(1'b0); qstep(1'b0);         // FFFD, FFFF
    cap_pin_hi = 1'b1; waitn(4);
    chk("R7 cap_hi own", cap_hi, 16'hFFFF);
    chk("R9 cap_lo untouched", cap_lo, 16'hFFFF);
    cap_pin_hi = 1'b0; waitn(4);

    // R9: routing on
    cfg_write(6'b010000);
    cap_pin_hi = 1'b1; waitn(4);
    chk("R9 routed cap_lo", cap_lo, 16'hFFFD);
    cap_pin_hi = 1'b0; waitn(4);

    // R8: low pin loads both
    cfg_write(6'b100000);
    qstep(1'b1); qstep(1'b1); qstep(1'b1);   // 0000, 0000
    cap_pin_lo = 1'b1; waitn(4);
    chk("R8 cap_lo", cap_lo, 16'h0000);
    chk("R8 cap_hi", cap_hi, 16'h0000);

    // R6: falling select on low channel, routed to high
    cfg_write(6'b100001);
    cap_pin_lo = 1'b0; waitn(4);             // falling edge at 0000
    qstep(1'b0);                              // FFFF, FFFF
    cap_pin_lo = 1'b1; waitn(4);
    chk("R6 rise ignored on fall select", cap_lo, 16'h0000);
    cap_pin_lo = 1'b0; waitn(4);
    chk("R6 fall capture lo", cap_lo, 16'hFFFF);
    chk("R6 R8 fall routed hi", cap_hi, 16'hFFFF);

    // R6: both-edge select on high channel
    cfg_write(6'b001001);
    qstep(1'b1);                              // 0000, 0000
    cap_pin_hi = 1'b1; waitn(4);
    chk("R6 both-edge rise", cap_hi, 16'h0000);
    qstep(1'b0);                              // FFFF, FFFF
    cap_pin_hi = 1'b0; waitn(4);
    chk("R6 both-edge fall", cap_hi, 16'hFFFF);
    chk("R9 hi edges leave cap_lo", cap_lo, 16'hFFFF);

    // R10: capture and step arrive together
    cfg_write(6'b001000);
    qidx = (qidx + 1) % 4;
    drive_phase(qidx);
    cap_pin_lo = 1'b1;
    waitn(4);
    chk("R10 pre-step value", cap_lo, 16'hFFFF);
    chk("R10 R4 count stepped", cnt_lo, 16'h0000);
    chk("R10 R4 hi stepped", cnt_hi, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule